// File: doc/BRIEF.md
# Bounded DMA Write Packer

This block sits between a serial receive engine that delivers one byte at a time and a memory port that takes 64-bit words. Software gives it a starting word address, counted in 8-byte units, and a byte count. The block then gathers the incoming bytes into words and hands each finished word to memory through a request/ready handshake. Successive words go to successive word addresses. If the stream ends partway through a word, the unused byte lanes of that last word are written as zero, so every transfer covers whole 8-byte words.

Each word address is compared against a programmable lower and upper bound. A word that falls outside that window is never requested from memory. The address still moves on, and a sticky out-of-range flag is raised that stays up until software pulses a clear input. A global mask input holds back every write request while it is set. A single-cycle done pulse marks the end of a transfer.

Control is a five-state machine. IDLE waits for a start pulse. FILL takes bytes into lanes. ISSUE holds a write request until it is accepted. DROP discards an out-of-window word. FINISH raises done.

The transitions are:
- IDLE to FILL on start.
- FILL to ISSUE when a word completes inside the window.
- FILL to DROP when a word completes outside the window.
- ISSUE or DROP back to FILL when more bytes remain.
- ISSUE or DROP to FINISH after the last word.
- FINISH to IDLE unconditionally.

Top module: `dma_word_packer`

## Requirements
- R1: After reset, wr_req, in_ready, done, busy and oor_flag are all 0.
- R2: The first byte of a word lands in wr_data[7:0] and byte k in wr_data[8k+7:8k]. The first word is written to base_addr and each later word to the previous address plus one.
- R3: A xfer_len of 0 means 65536 bytes, which is 8192 words.
- R4: A transfer of L bytes produces ceil(L/8) words. The lanes of the last word that no byte reaches are 0x00.
- R5: While wr_req is high and wr_ready is low, wr_req stays high (unless masked) and wr_addr and wr_data stay constant. in_ready is low whenever wr_req is high.
- R6: A word is requested only if win_lo <= address <= win_hi (both ends inclusive). A word outside that range issues no request, and the next word still uses the following address.
- R7: oor_flag goes to 1 in the cycle after a dropped word and stays 1 until oor_clear is sampled high. When a drop and oor_clear coincide, the set wins.
- R8: While req_mask is 1, wr_req is 0. A word completed during the mask is requested once the mask drops.
- R9: done is a single-cycle pulse after the final word has been accepted or dropped. busy is low afterwards.
- R10: A start pulse while busy is ignored. The running transfer keeps its base address and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted in IDLE only) |
| base_addr | input | 26 | First word address in 8-byte units |
| xfer_len | input | 16 | Byte count, 0 means 65536 |
| win_lo | input | 26 | Lowest allowed word address |
| win_hi | input | 26 | Highest allowed word address |
| req_mask | input | 1 | Holds off all write requests |
| oor_clear | input | 1 | Clears the out-of-range flag |
| in_valid | input | 1 | Incoming byte valid |
| in_data | input | 8 | Incoming byte |
| in_ready | output | 1 | Byte accepted this cycle when in_valid is high |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | 26 | Write word address |
| wr_data | output | 64 | Write data |
| wr_ready | input | 1 | Memory accepts the request |
| oor_flag | output | 1 | Sticky out-of-range indication |
| done | output | 1 | Transfer complete pulse |
| busy | output | 1 | Transfer in progress |

## Verification
Two events can land on the same edge: a DROP setting the out-of-range flag, and software clearing it. The bench holds oor_clear high for a whole transfer in which exactly one word lies outside the window. With set taking priority, the flag must be seen high for exactly one cycle, then drop on the next edge. A second pair that can coincide is back-pressure and masking. The bench raises the mask while a word waits for ready, and expects the request to vanish, its address and data to persist, and one write to occur after release.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_ISSUE,
        ST_DROP,
        ST_FINISH
    } wpk_state_e;

endpackage

// File: rtl/wpk_lane_buf.sv
module wpk_lane_buf #(
    parameter int WORD_BYTES = 8,
    localparam int LANE_W = $clog2(WORD_BYTES),
    localparam int DATA_W = WORD_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [7:0]        din,
    output logic [DATA_W-1:0] word,
    output logic              lane_last
);

    logic [LANE_W-1:0] lane_q;
    logic [7:0]        lane_byte [WORD_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lane_q <= '0;
        else if (clr)   lane_q <= '0;
        else if (push)  lane_q <= lane_q + 1'b1;
    end

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lane_byte[g] <= '0;
            else if (clr)
                lane_byte[g] <= '0;
            else if (push && lane_q == LANE_W'(g))
                lane_byte[g] <= din;
        end
        assign word[g*8 +: 8] = lane_byte[g];
    end

    assign lane_last = (lane_q == LANE_W'(WORD_BYTES - 1));

endmodule

// File: rtl/wpk_addr_ctr.sv
module wpk_addr_ctr #(
    parameter int ADDR_W = 26,
    parameter int LEN_W  = 16,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic              byte_take,
    input  logic              word_adv,
    output logic [ADDR_W-1:0] addr,
    output logic              rem_last,
    output logic              rem_zero
);

    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] rem_init;

    assign rem_init = (len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         addr <= '0;
        else if (load)      addr <= base;
        else if (word_adv)  addr <= addr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rem_q <= '0;
        else if (load)      rem_q <= rem_init;
        else if (byte_take) rem_q <= rem_q - 1'b1;
    end

    assign rem_last = (rem_q == CNT_W'(1));
    assign rem_zero = (rem_q == '0);

endmodule

// File: rtl/wpk_window.sv
module wpk_window #(
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic              viol_set,
    input  logic              viol_clr,
    output logic              in_win,
    output logic              viol_flag
);

    assign in_win = (addr >= lo) && (addr <= hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         viol_flag <= 1'b0;
        else if (viol_set)  viol_flag <= 1'b1;
        else if (viol_clr)  viol_flag <= 1'b0;
    end

endmodule

// File: rtl/wpk_fsm.sv
module wpk_fsm
    import wpk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    input  logic lane_last,
    input  logic rem_last,
    input  logic rem_zero,
    input  logic in_win,
    input  logic req_mask,
    input  logic wr_ready,
    output logic in_ready,
    output logic wr_req,
    output logic load,
    output logic buf_clr,
    output logic byte_take,
    output logic word_adv,
    output logic viol_set,
    output logic done,
    output logic busy
);

    wpk_state_e state_q, state_d;
    logic       word_end;
    logic       accepted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign word_end = in_valid && (lane_last || rem_last);
    assign accepted = !req_mask && wr_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_FILL;
            ST_FILL:   if (word_end) state_d = in_win ? ST_ISSUE : ST_DROP;
            ST_ISSUE:  if (accepted) state_d = rem_zero ? ST_FINISH : ST_FILL;
            ST_DROP:   state_d = rem_zero ? ST_FINISH : ST_FILL;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        wr_req    = 1'b0;
        load      = 1'b0;
        buf_clr   = 1'b0;
        byte_take = 1'b0;
        word_adv  = 1'b0;
        viol_set  = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy    = 1'b0;
                load    = start;
                buf_clr = start;
            end
            ST_FILL: begin
                in_ready  = 1'b1;
                byte_take = in_valid;
            end
            ST_ISSUE: begin
                wr_req   = !req_mask;
                word_adv = accepted;
                buf_clr  = accepted;
            end
            ST_DROP: begin
                viol_set = 1'b1;
                word_adv = 1'b1;
                buf_clr  = 1'b1;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_word_packer.sv
module dma_word_packer #(
    parameter int ADDR_W     = 26,
    parameter int LEN_W      = 16,
    parameter int WORD_BYTES = 8,
    localparam int DATA_W    = WORD_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [ADDR_W-1:0] win_lo,
    input  logic [ADDR_W-1:0] win_hi,
    input  logic              req_mask,
    input  logic              oor_clear,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              oor_flag,
    output logic              done,
    output logic              busy
);

    logic load, buf_clr, byte_take, word_adv, viol_set;
    logic lane_last, rem_last, rem_zero, in_win;

    wpk_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .lane_last (lane_last),
        .rem_last  (rem_last),
        .rem_zero  (rem_zero),
        .in_win    (in_win),
        .req_mask  (req_mask),
        .wr_ready  (wr_ready),
        .in_ready  (in_ready),
        .wr_req    (wr_req),
        .load      (load),
        .buf_clr   (buf_clr),
        .byte_take (byte_take),
        .word_adv  (word_adv),
        .viol_set  (viol_set),
        .done      (done),
        .busy      (busy)
    );

    wpk_lane_buf #(.WORD_BYTES(WORD_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .push      (byte_take),
        .din       (in_data),
        .word      (wr_data),
        .lane_last (lane_last)
    );

    wpk_addr_ctr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .base      (base_addr),
        .len       (xfer_len),
        .byte_take (byte_take),
        .word_adv  (word_adv),
        .addr      (wr_addr),
        .rem_last  (rem_last),
        .rem_zero  (rem_zero)
    );

    wpk_window #(.ADDR_W(ADDR_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (wr_addr),
        .lo        (win_lo),
        .hi        (win_hi),
        .viol_set  (viol_set),
        .viol_clr  (oor_clear),
        .in_win    (in_win),
        .viol_flag (oor_flag)
    );

endmodule

// File: rtl/wpk_checker.sv
module wpk_checker #(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              req_mask,
    input logic              oor_clear,
    input logic              in_ready,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] win_lo,
    input logic [ADDR_W-1:0] win_hi,
    input logic              wr_ready,
    input logic              oor_flag,
    input logic              done,
    input logic              busy
);

    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ready) |=> ((wr_req || req_mask) && $stable(wr_addr) && $stable(wr_data)));

    a_r5_no_byte_during_req: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !in_ready);

    a_r6_req_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_addr >= win_lo && wr_addr <= win_hi));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (oor_flag && !oor_clear) |=> oor_flag);

    a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        req_mask |-> !wr_req);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind dma_word_packer wpk_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_mask  (req_mask),
    .oor_clear (oor_clear),
    .in_ready  (in_ready),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .win_lo    (win_lo),
    .win_hi    (win_hi),
    .wr_ready  (wr_ready),
    .oor_flag  (oor_flag),
    .done      (done),
    .busy      (busy)
);

// File: tb/dma_word_packer_bench.sv
module dma_word_packer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [25:0] base_addr = '0;
    logic [15:0] xfer_len = '0;
    logic [25:0] win_lo = '0;
    logic [25:0] win_hi = '1;
    logic        req_mask = 1'b0;
    logic        oor_clear = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        wr_req;
    logic [25:0] wr_addr;
    logic [63:0] wr_data;
    logic        wr_ready = 1'b1;
    logic        oor_flag;
    logic        done;
    logic        busy;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dma_word_packer u_dma_word_packer (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .xfer_len(xfer_len), .win_lo(win_lo), .win_hi(win_hi),
        .req_mask(req_mask), .oor_clear(oor_clear), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .oor_flag(oor_flag), .done(done), .busy(busy)
    );

    // monitor, samples on falling edges
    int          cap_cnt = 0;
    logic [25:0] cap_addr [16];
    logic [63:0] cap_data [16];
    logic [25:0] last_addr;
    logic [63:0] last_data;
    int          done_cnt = 0;
    int          done_wide = 0;
    int          oor_hi_cnt = 0;
    logic        done_prev = 1'b0;

    always @(negedge clk) begin
        if (wr_req && wr_ready) begin
            if (cap_cnt < 16) begin
                cap_addr[cap_cnt] = wr_addr;
                cap_data[cap_cnt] = wr_data;
            end
            last_addr = wr_addr;
            last_data = wr_data;
            cap_cnt++;
        end
        if (done) done_cnt++;
        if (done && done_prev) done_wide++;
        done_prev = done;
        if (oor_flag) oor_hi_cnt++;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int seed, input int i);
        return 8'(seed + i * 5 + 1);
    endfunction

    function automatic logic [63:0] exp_word(input int seed, input int len, input int w);
        logic [63:0] r = '0;
        for (int k = 0; k < 8; k++)
            if (w * 8 + k < len) r[k*8 +: 8] = byte_of(seed, w * 8 + k);
        return r;
    endfunction

    task automatic kick(input logic [25:0] b, input logic [15:0] l);
        @(negedge clk);
        base_addr = b; xfer_len = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_bytes(input int n, input int seed);
        for (int i = 0; i < n; ) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = byte_of(seed, i);
            if (in_ready) i++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 100000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic clear_caps();
        cap_cnt = 0; done_cnt = 0; done_wide = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!wr_req && !in_ready && !done && !busy && !oor_flag, "R1 reset outputs",
            {wr_req, in_ready, done, busy, oor_flag}, 0);
    endtask

    task automatic t_basic();
        clear_caps();
        kick(26'd100, 16'd16);
        send_bytes(16, 3);
        wait_done();
        chk(cap_cnt == 2, "R2 word count", cap_cnt, 2);
        chk(cap_addr[0] == 26'd100, "R2 first address", cap_addr[0], 100);
        chk(cap_addr[1] == 26'd101, "R2 second address", cap_addr[1], 101);
        chk(cap_data[0] == exp_word(3, 16, 0), "R2 lane order word0", cap_data[0], exp_word(3, 16, 0));
        chk(cap_data[1] == exp_word(3, 16, 1), "R2 lane order word1", cap_data[1], exp_word(3, 16, 1));
        chk(done_cnt == 1 && done_wide == 0, "R9 single done pulse", done_cnt, 1);
        chk(!busy, "R9 idle after done", busy, 0);
    endtask

    task automatic t_pad();
        clear_caps();
        kick(26'd7, 16'd13);
        send_bytes(13, 9);
        wait_done();
        chk(cap_cnt == 2, "R4 ceil word count 13", cap_cnt, 2);
        chk(cap_data[1] == exp_word(9, 13, 1), "R4 zero padding", cap_data[1], exp_word(9, 13, 1));
        clear_caps();
        kick(26'd20, 16'd3);
        send_bytes(3, 40);
        wait_done();
        chk(cap_cnt == 1 && cap_data[0] == exp_word(40, 3, 0), "R4 three byte word",
            cap_data[0], exp_word(40, 3, 0));
    endtask

    task automatic t_stall();
        logic [25:0] a0;
        logic [63:0] d0;
        bit          ok = 1'b1;
        clear_caps();
        @(posedge clk) wr_ready <= 1'b0;
        kick(26'd300, 16'd16);
        fork
            send_bytes(16, 77);
            begin
                while (!wr_req) @(negedge clk);
                a0 = wr_addr; d0 = wr_data;
                repeat (5) begin
                    @(negedge clk);
                    if (!wr_req || wr_addr != a0 || wr_data != d0 || in_ready) ok = 1'b0;
                end
                chk(ok, "R5 request held under back-pressure", {wr_req, in_ready}, 2'b10);
                // mask while pending
                req_mask = 1'b1;
                @(negedge clk);
                chk(!wr_req && wr_addr == a0 && wr_data == d0, "R8 mask drops request",
                    wr_req, 0);
                @(posedge clk) wr_ready <= 1'b1;
                repeat (4) @(negedge clk);
                chk(cap_cnt == 0, "R8 no write while masked", cap_cnt, 0);
                req_mask = 1'b0;
            end
        join
        wait_done();
        chk(cap_cnt == 2 && cap_addr[0] == 26'd300 && cap_data[0] == exp_word(77, 16, 0),
            "R8 write after unmask", cap_cnt, 2);
    endtask

    task automatic t_window();
        clear_caps();
        win_lo = 26'd11; win_hi = 26'd12;
        kick(26'd10, 16'd32);
        send_bytes(32, 5);
        wait_done();
        chk(cap_cnt == 2, "R6 only in-window words", cap_cnt, 2);
        chk(cap_addr[0] == 26'd11 && cap_data[0] == exp_word(5, 32, 1), "R6 lower edge inclusive",
            cap_addr[0], 11);
        chk(cap_addr[1] == 26'd12 && cap_data[1] == exp_word(5, 32, 2), "R6 upper edge inclusive",
            cap_addr[1], 12);
        chk(oor_flag, "R7 flag set after drop", oor_flag, 1);
        repeat (10) @(negedge clk);
        chk(oor_flag, "R7 flag sticky", oor_flag, 1);
        oor_clear = 1'b1;
        @(negedge clk);
        oor_clear = 1'b0;
        @(negedge clk);
        chk(!oor_flag, "R7 flag cleared", oor_flag, 0);
        win_lo = '0; win_hi = '1;
    endtask

    task automatic t_set_vs_clear();
        clear_caps();
        win_lo = 26'd51; win_hi = 26'd60;
        oor_clear = 1'b1;
        @(negedge clk);
        oor_hi_cnt = 0;
        kick(26'd50, 16'd16);
        send_bytes(16, 12);
        wait_done();
        chk(oor_hi_cnt == 1, "R7 set wins over clear for one cycle", oor_hi_cnt, 1);
        chk(cap_cnt == 1 && cap_addr[0] == 26'd51, "R6 dropped word advances address",
            cap_addr[0], 51);
        oor_clear = 1'b0;
        win_lo = '0; win_hi = '1;
    endtask

    task automatic t_busy_start();
        clear_caps();
        kick(26'd200, 16'd16);
        fork
            send_bytes(16, 21);
            begin
                repeat (3) @(negedge clk);
                base_addr = 26'd999; xfer_len = 16'd8; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        wait_done();
        chk(cap_cnt == 2 && cap_addr[0] == 26'd200 && cap_addr[1] == 26'd201,
            "R10 start ignored while busy", cap_addr[1], 201);
    endtask

    task automatic t_full();
        clear_caps();
        kick(26'd1000, 16'd0);
        send_bytes(65536, 2);
        wait_done();
        chk(cap_cnt == 8192, "R3 zero length gives 8192 words", cap_cnt, 8192);
        chk(last_addr == 26'd9191, "R3 last address", last_addr, 9191);
        chk(last_data == exp_word(2, 65536, 8191), "R3 last word data", last_data,
            exp_word(2, 65536, 8191));
        chk(done_cnt == 1, "R9 done after full transfer", done_cnt, 1);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_pad();
        t_stall();
        t_window();
        t_set_vs_clear();
        t_busy_start();
        t_full();
        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 190000) begin @(negedge clk); cyc++; end
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule